// File: doc/BRIEF.md
# Bus Controller Operating-Mode Sequencer

This block decides which operating mode a time-triggered bus communication controller is in. Each cycle it reads the mode-control bits written by the host and a clock-synchronization failure flag. From these and the current mode it picks the next mode. The modes are configuration, normal active, normal passive, listen-only, debug, diagnostic stop and sleep.

From the current mode it drives four gating outputs. Three of them enable transmission, reception and clock synchronization. The fourth grants full write access to the configuration registers. It also reports the mode as a 3-bit code and pulses a flag on every mode change.

Normal operation can be reached only through configuration. The diagnostic stop takes effect on the next clock edge, without waiting for any protocol boundary, and it can only be left towards configuration. Listen-only can be requested by the host or forced by a loss of clock synchronization.

Top module: `ccm_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, the mode is configuration: `tx_en_o`, `rx_en_o` and `sync_en_o` are 0, `cfg_wr_o` is 1 and `mode_chg_o` is 0.
- R2: With `dstop_i` high at a clock edge, the mode after that edge is diagnostic stop, whatever the current mode and whatever the other inputs are.
- R3: Diagnostic stop is held while `dstop_i` stays high. When it is low, the next mode is configuration, and no other mode is ever entered from diagnostic stop.
- R4: Normal active is entered only from configuration, on an edge where `cfg_i` is low and `dstop_i` is low. Configuration holds while `cfg_i` is high.
- R5: From normal active, normal passive, listen-only, debug and sleep, `cfg_i` high (with `dstop_i` low) returns the mode to configuration.
- R6: From normal active and normal passive, simultaneous exit conditions resolve in this order: diagnostic stop, configure, sleep, debug, listen-only. With none of them true, the mode holds.
- R7: From normal active or normal passive, `sync_fail_i` high enters listen-only, with the same priority as `lo_i`.
- R8: Listen-only holds while `lo_i` or `sync_fail_i` is high. With both low (and no stop or configure), it moves to normal passive. Debug and sleep are left only by configure or diagnostic stop.
- R9: The gating outputs {tx, rx, sync, cfg_wr} per mode are: configuration 0001, normal active 1110, normal passive 0110, listen-only 0110, debug 0100, diagnostic stop 0000, sleep 0000.
- R10: `mode_o` codes are: configuration 0, normal active 1, normal passive 2, listen-only 3, debug 4, diagnostic stop 5, sleep 6.
- R11: `mode_chg_o` is high for exactly the first cycle after an edge that changed the mode, and low otherwise.
- R12: Sleep is entered only when `slp_req_i` and `slp_ack_i` are both high. Either bit alone has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Host configure request |
| dstop_i | input | 1 | Host diagnostic stop request |
| dbg_i | input | 1 | Host debug request |
| lo_i | input | 1 | Host listen-only request |
| slp_req_i | input | 1 | Host sleep request |
| slp_ack_i | input | 1 | Sleep acknowledge |
| sync_fail_i | input | 1 | Clock synchronization failure flag |
| mode_o | output | 3 | Current mode code |
| mode_chg_o | output | 1 | One-cycle pulse after a mode change |
| tx_en_o | output | 1 | Transmission enable |
| rx_en_o | output | 1 | Reception enable |
| sync_en_o | output | 1 | Clock synchronization enable |
| cfg_wr_o | output | 1 | Full configuration register write access |

## Verification
The block has no parameters, so the bench builds it as it stands. Its whole state space is seven modes times 128 input combinations, and that is small enough for a complete sweep. The bench steers the design into each mode and applies every input combination for one edge. It then compares the new mode, the change pulse and the four gates against a model written from the tables above. Every priority clash, every lone sleep bit and every exit from every mode is therefore covered.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic [2:0] {
    M_CFG   = 3'd0,
    M_ACT   = 3'd1,
    M_PAS   = 3'd2,
    M_LSTN  = 3'd3,
    M_DBG   = 3'd4,
    M_DSTOP = 3'd5,
    M_SLEEP = 3'd6
  } mode_e;

  typedef struct packed {
    logic cfg;
    logic dstop;
    logic dbg;
    logic lo;
    logic slp_req;
    logic slp_ack;
    logic sync_fail;
  } ctrl_t;

  typedef struct packed {
    logic tx;
    logic rx;
    logic sync;
    logic cfg_wr;
  } gate_t;
endpackage

// File: rtl/ccm_next_mode.sv
module ccm_next_mode
  import ccm_pkg::*;
(
  input  mode_e cur_i,
  input  ctrl_t ctl_i,
  output mode_e nxt_o
);
  logic slp_ok;
  assign slp_ok = ctl_i.slp_req & ctl_i.slp_ack;

  always_comb begin
    nxt_o = cur_i;
    if (ctl_i.dstop) begin
      nxt_o = M_DSTOP;
    end else begin
      unique case (cur_i)
        M_CFG:   if (!ctl_i.cfg) nxt_o = M_ACT;
        M_DSTOP: nxt_o = M_CFG;
        M_ACT, M_PAS: begin
          if (ctl_i.cfg)                      nxt_o = M_CFG;
          else if (slp_ok)                    nxt_o = M_SLEEP;
          else if (ctl_i.dbg)                 nxt_o = M_DBG;
          else if (ctl_i.lo || ctl_i.sync_fail) nxt_o = M_LSTN;
        end
        M_LSTN: begin
          if (ctl_i.cfg)                           nxt_o = M_CFG;
          else if (!ctl_i.lo && !ctl_i.sync_fail)  nxt_o = M_PAS;
        end
        M_DBG, M_SLEEP: if (ctl_i.cfg) nxt_o = M_CFG;
        default: nxt_o = M_CFG;
      endcase
    end
  end
endmodule

// File: rtl/ccm_mode_decode.sv
module ccm_mode_decode
  import ccm_pkg::*;
(
  input  mode_e mode_i,
  output gate_t gate_o
);
  always_comb begin
    unique case (mode_i)
      M_CFG:   gate_o = '{tx: 1'b0, rx: 1'b0, sync: 1'b0, cfg_wr: 1'b1};
      M_ACT:   gate_o = '{tx: 1'b1, rx: 1'b1, sync: 1'b1, cfg_wr: 1'b0};
      M_PAS,
      M_LSTN:  gate_o = '{tx: 1'b0, rx: 1'b1, sync: 1'b1, cfg_wr: 1'b0};
      M_DBG:   gate_o = '{tx: 1'b0, rx: 1'b1, sync: 1'b0, cfg_wr: 1'b0};
      default: gate_o = '0;
    endcase
  end
endmodule

// File: rtl/ccm_mode_ctrl.sv
module ccm_mode_ctrl
  import ccm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_i,
  input  logic       dstop_i,
  input  logic       dbg_i,
  input  logic       lo_i,
  input  logic       slp_req_i,
  input  logic       slp_ack_i,
  input  logic       sync_fail_i,
  output logic [2:0] mode_o,
  output logic       mode_chg_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       sync_en_o,
  output logic       cfg_wr_o
);
  ctrl_t ctl;
  mode_e mode_q, mode_d;
  gate_t gate;
  logic  chg_q;

  assign ctl = '{cfg: cfg_i, dstop: dstop_i, dbg: dbg_i, lo: lo_i,
                 slp_req: slp_req_i, slp_ack: slp_ack_i, sync_fail: sync_fail_i};

  ccm_next_mode u_next (.cur_i(mode_q), .ctl_i(ctl), .nxt_o(mode_d));
  ccm_mode_decode u_dec (.mode_i(mode_q), .gate_o(gate));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_CFG;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= (mode_d != mode_q);
    end
  end

  assign mode_o     = mode_q;
  assign mode_chg_o = chg_q;
  assign tx_en_o    = gate.tx;
  assign rx_en_o    = gate.rx;
  assign sync_en_o  = gate.sync;
  assign cfg_wr_o   = gate.cfg_wr;

  // R2
  dstop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstop_i |=> mode_o == 3'd5);

  // R3
  dstop_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd0));

  // R4
  act_from_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && $past(mode_o) != 3'd1) |-> $past(mode_o) == 3'd0);

  // R7
  sync_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && sync_fail_i && !dstop_i && !cfg_i && !dbg_i &&
     !(slp_req_i && slp_ack_i)) |=> mode_o == 3'd3);

  // R9
  tx_only_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> mode_o == 3'd1);

  // R11
  chg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> mode_o != $past(mode_o));
endmodule

// File: tb/tb_ccm_mode_ctrl.sv
module tb_ccm_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_i, dstop_i, dbg_i, lo_i, slp_req_i, slp_ack_i, sync_fail_i;
  logic [2:0] mode_o;
  logic mode_chg_o, tx_en_o, rx_en_o, sync_en_o, cfg_wr_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccm_mode_ctrl dut (.*, .clk_i(clk));

  function automatic logic [2:0] model_next(input logic [2:0] s, input logic [6:0] v);
    logic c, d, g, l, r, a, f;
    {c, d, g, l, r, a, f} = v;
    if (d) return 3'd5;
    case (s)
      3'd0: return c ? 3'd0 : 3'd1;
      3'd5: return 3'd0;
      3'd1, 3'd2: begin
        if (c) return 3'd0;
        if (r && a) return 3'd6;
        if (g) return 3'd4;
        if (l || f) return 3'd3;
        return s;
      end
      3'd3: return c ? 3'd0 : ((l || f) ? 3'd3 : 3'd2);
      default: return c ? 3'd0 : s;
    endcase
  endfunction

  function automatic logic [3:0] model_gate(input logic [2:0] m);
    case (m)
      3'd0: return 4'b0001;
      3'd1: return 4'b1110;
      3'd2, 3'd3: return 4'b0110;
      3'd4: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input logic [6:0] v);
    if (v[5]) return "R2";
    if (s == 3'd5) return "R3";
    if (s == 3'd0) return "R4";
    if (v[6]) return "R5";
    if ((s == 3'd1 || s == 3'd2) && (v[2] ^ v[1])) return "R12";
    if ((s == 3'd1 || s == 3'd2) && v[0]) return "R7";
    if (s == 3'd1 || s == 3'd2) return "R6";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] v);
    @(negedge clk);
    {cfg_i, dstop_i, dbg_i, lo_i, slp_req_i, slp_ack_i, sync_fail_i} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    {cfg_i, dstop_i, dbg_i, lo_i, slp_req_i, slp_ack_i, sync_fail_i} = 7'b1000000;
    #1;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // bit order: cfg dstop dbg lo slp_req slp_ack sync_fail
  task automatic goto_mode(input logic [2:0] m);
    do_reset();
    case (m)
      3'd1: step(7'b0000000);
      3'd2: begin step(7'b0000000); step(7'b0001000); step(7'b0000000); end
      3'd3: begin step(7'b0000000); step(7'b0001000); end
      3'd4: begin step(7'b0000000); step(7'b0010000); end
      3'd5: step(7'b1100000);
      3'd6: begin step(7'b0000000); step(7'b0000110); end
      default: step(7'b1000000);
    endcase
    // R10 code of the reached mode
    check("R10", {29'd0, mode_o}, {29'd0, m});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {cfg_i, dstop_i, dbg_i, lo_i, slp_req_i, slp_ack_i, sync_fail_i} = 7'b1000000;
    #(CLK_PERIOD * 2 + 1);
    // R1 in reset
    check("R1", {mode_o, tx_en_o, rx_en_o, sync_en_o, cfg_wr_o, mode_chg_o}, {3'd0, 4'b0001, 1'b0});
    rst_ni = 1'b1;
    @(posedge clk); #1;
    // R1 after release, configure held
    check("R1", {mode_o, tx_en_o, rx_en_o, sync_en_o, cfg_wr_o, mode_chg_o}, {3'd0, 4'b0001, 1'b0});

    for (int s = 0; s < 7; s++) begin
      for (int v = 0; v < 128; v++) begin
        logic [2:0] exp_m;
        goto_mode(s[2:0]);
        exp_m = model_next(s[2:0], v[6:0]);
        step(v[6:0]);
        check(tag_of(s[2:0], v[6:0]), {29'd0, mode_o}, {29'd0, exp_m});
        // R9 gates follow the new mode
        check("R9", {28'd0, tx_en_o, rx_en_o, sync_en_o, cfg_wr_o}, {28'd0, model_gate(exp_m)});
        // R11 pulse in first cycle of new mode only
        check("R11", {31'd0, mode_chg_o}, {31'd0, exp_m != s[2:0]});
        step(v[6:0]);
        if (model_next(exp_m, v[6:0]) == exp_m)
          check("R11", {31'd0, mode_chg_o}, 32'd0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule